// File: doc/BRIEF.md
# Shared-Path Channel Sequencer

This block owns the single 16-bit parallel path to an external serial-bus controller. That controller has two receive channels and one transmit channel, and all three must reach the core through this one path. The sequencer samples the controller's per-receiver data-ready flags (active low) and its transmit half-full flag. It also samples the fill state of the core's own queues. From these it picks one channel and moves one 32-bit word across the path.

A word always crosses as two 16-bit halves on two consecutive cycles, low half first. A half-select output marks which half is on the path. A received word is assembled and pushed into the queue for its channel. A transmitted word is taken from the head of the transmit queue and popped after its high half has gone out.

Every transfer is followed by one clear cycle. In that cycle every strobe, the half-select and the outgoing data return to zero, and only then does the machine go back to waiting. The serial word layout is label in word bits 1–8, source/destination in 9–10, data in 11–29, sign/status in 30–31 and parity in bit 32. It passes through unchanged: word bit n appears on path line n-1 of the low half for n ≤ 16, and on line n-17 of the high half otherwise.

Top module: `shpath_arbiter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the block is waiting. All enables, half_sel, queue handshakes, bus_dout and rxq_wdata are zero.
- R2: Requests are sampled only at a clock edge while waiting. When several are eligible at once, receiver 1 is served first, then receiver 2, then transmit.
- R3: Receiver k is eligible only when rxk_rdy_n is 0 and rxkq_full is 0. Transmit is eligible only when txq_empty is 0 and tx_hfull is 0.
- R4: A granted transfer occupies exactly two cycles. The channel's enable (rd_en1, rd_en2 or wr_en) is high in both cycles, with half_sel 0 in the first and 1 in the second.
- R5: In the second cycle of a receive, the matching rxkq_push is high for that cycle only. rxq_wdata then equals {bus_din of that cycle, bus_din of the first cycle}, so words enter each queue in the order they left the controller.
- R6: During a transmit, bus_dout carries txq_data[15:0] in the first cycle and txq_data[31:16] in the second. txq_pop is high in the second cycle only, and bus_dout is zero whenever wr_en is low.
- R7: Every transfer is followed by exactly one clear cycle with all outputs zero, then one waiting cycle before the next grant.
- R8: At most one of rd_en1, rd_en2 and wr_en is high in any cycle, and at most one queue handshake is high.
- R9: A flag or queue status that changes while a transfer is in progress neither shortens, extends nor redirects that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx1_rdy_n | input | 1 | Controller receiver 1 holds data (active low) |
| rx2_rdy_n | input | 1 | Controller receiver 2 holds data (active low) |
| tx_hfull | input | 1 | Controller transmit buffer half full |
| bus_din | input | 16 | Half word read from the controller |
| bus_dout | output | 16 | Half word written to the controller |
| rd_en1 | output | 1 | Read strobe, receiver 1 |
| rd_en2 | output | 1 | Read strobe, receiver 2 |
| wr_en | output | 1 | Write strobe, transmitter |
| half_sel | output | 1 | 0 = low half on the path, 1 = high half |
| txq_empty | input | 1 | Internal transmit queue is empty |
| txq_data | input | 32 | Head word of the internal transmit queue |
| txq_pop | output | 1 | Remove head of the transmit queue |
| rx1q_full | input | 1 | Internal receiver-1 queue is full |
| rx2q_full | input | 1 | Internal receiver-2 queue is full |
| rx1q_push | output | 1 | Push rxq_wdata into the receiver-1 queue |
| rx2q_push | output | 1 | Push rxq_wdata into the receiver-2 queue |
| rxq_wdata | output | 32 | Assembled received word |

## Verification
The sharpest collision is between a sampled request and a transfer already in flight. A channel's flag can fall, a queue can fill, or the half-full flag can rise in the same cycle that another channel's low or high half is on the path. Only the waiting-state edge may act on such a change.

The bench provokes this in two ways. A directed phase raises all three requests together and holds a blocked receiver and a blocked transmitter. A long random phase changes every flag and queue status on any cycle. A behavioural model, built from queues, predicts the strobe, half, push, pop and data values for every cycle, and the grant order is also checked against the stated priority.

// File: rtl/shpath_pkg.sv
package shpath_pkg;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int NREQ    = 3;
  // Request index order is the service priority (lowest index wins)
  localparam int REQ_RX1 = 0;
  localparam int REQ_RX2 = 1;
  localparam int REQ_TX  = 2;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_TX   = 3'd1,
    ST_RX1  = 3'd2,
    ST_RX2  = 3'd3,
    ST_CLR  = 3'd4
  } path_state_e;
endpackage

// File: rtl/shpath_grant.sv
module shpath_grant #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // blocked[i] is high when any lower-index request is present
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pick
      assign grant[i] = req[i] & ~blocked[i];
      if (i < N - 1) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
      end
    end
  endgenerate

  always_comb begin
    a_r8_grant_onehot: assert ($onehot0(grant));
  end
endmodule

// File: rtl/shpath_seq.sv
module shpath_seq
  import shpath_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  grant,
  output path_state_e      state_q,
  output logic             half_q
);
  path_state_e state_d;
  logic        half_d;
  logic        in_xfer;

  assign in_xfer = (state_q == ST_TX) || (state_q == ST_RX1) || (state_q == ST_RX2);

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    unique case (state_q)
      ST_WAIT: begin
        half_d = 1'b0;
        if (grant[REQ_RX1])      state_d = ST_RX1;
        else if (grant[REQ_RX2]) state_d = ST_RX2;
        else if (grant[REQ_TX])  state_d = ST_TX;
      end
      ST_TX, ST_RX1, ST_RX2: begin
        if (!half_q) begin
          half_d = 1'b1;
        end else begin
          half_d  = 1'b0;
          state_d = ST_CLR;
        end
      end
      ST_CLR:  state_d = ST_WAIT;
      default: begin
        state_d = ST_WAIT;
        half_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  // R4 / R9: low half is always followed by the high half of the same channel
  a_r4_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !half_q) |=> (half_q && state_q == $past(state_q)));

  // R7: clear cycle after the high half, then back to waiting
  a_r7_clear_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && half_q) |=> (state_q == ST_CLR));
  a_r7_back_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLR) |=> (state_q == ST_WAIT));

  // R2: receiver 1 wins whenever it is eligible at a waiting edge
  a_r2_rx1_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && grant[REQ_RX1]) |=> (state_q == ST_RX1 && !half_q));
endmodule

// File: rtl/shpath_datapath.sv
module shpath_datapath
  import shpath_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  path_state_e       state_q,
  input  logic              half_q,
  input  logic [HALF_W-1:0] bus_din,
  input  logic [WORD_W-1:0] txq_data,
  output logic [HALF_W-1:0] bus_dout,
  output logic              rd_en1,
  output logic              rd_en2,
  output logic              wr_en,
  output logic              half_sel,
  output logic              txq_pop,
  output logic              rx1q_push,
  output logic              rx2q_push,
  output logic [WORD_W-1:0] rxq_wdata
);
  logic [HALF_W-1:0] lo_q;
  logic              lo_en;
  logic              rx_any;

  assign rd_en1   = (state_q == ST_RX1);
  assign rd_en2   = (state_q == ST_RX2);
  assign wr_en    = (state_q == ST_TX);
  assign rx_any   = rd_en1 | rd_en2;
  assign half_sel = (rx_any | wr_en) & half_q;

  // Low half of a received word is held until the high half arrives
  assign lo_en = rx_any & ~half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= bus_din;
    end
  end

  assign rx1q_push = rd_en1 & half_q;
  assign rx2q_push = rd_en2 & half_q;
  assign rxq_wdata = (rx1q_push | rx2q_push) ? {bus_din, lo_q} : '0;

  assign txq_pop  = wr_en & half_q;
  assign bus_dout = !wr_en ? '0 :
                    (half_q ? txq_data[WORD_W-1:HALF_W] : txq_data[HALF_W-1:0]);

  // R8: a single strobe on the shared path
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en1, rd_en2, wr_en}));
  a_r8_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx1q_push, rx2q_push, txq_pop}));

  // R5: a push closes a read whose previous cycle carried the low half
  a_r5_push_after_low1: assert property (@(posedge clk) disable iff (!rst_n)
    rx1q_push |-> ($past(rd_en1) && !$past(half_sel)));
  a_r5_push_after_low2: assert property (@(posedge clk) disable iff (!rst_n)
    rx2q_push |-> ($past(rd_en2) && !$past(half_sel)));

  // R6: pop only with the high half, data quiet without a write
  a_r6_pop_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (wr_en && half_sel && $past(wr_en)));
  a_r6_quiet_dout: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (bus_dout == '0));
endmodule

// File: rtl/shpath_arbiter.sv
module shpath_arbiter
  import shpath_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx1_rdy_n,
  input  logic              rx2_rdy_n,
  input  logic              tx_hfull,
  input  logic [HALF_W-1:0] bus_din,
  output logic [HALF_W-1:0] bus_dout,
  output logic              rd_en1,
  output logic              rd_en2,
  output logic              wr_en,
  output logic              half_sel,
  input  logic              txq_empty,
  input  logic [WORD_W-1:0] txq_data,
  output logic              txq_pop,
  input  logic              rx1q_full,
  input  logic              rx2q_full,
  output logic              rx1q_push,
  output logic              rx2q_push,
  output logic [WORD_W-1:0] rxq_wdata
);
  logic [NREQ-1:0] req;
  logic [NREQ-1:0] grant;
  path_state_e     state_q;
  logic            half_q;

  assign req[REQ_RX1] = ~rx1_rdy_n & ~rx1q_full;
  assign req[REQ_RX2] = ~rx2_rdy_n & ~rx2q_full;
  assign req[REQ_TX]  = ~txq_empty & ~tx_hfull;

  shpath_grant #(.N(NREQ)) u_grant (
    .req   (req),
    .grant (grant)
  );

  shpath_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (grant),
    .state_q (state_q),
    .half_q  (half_q)
  );

  shpath_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .half_q    (half_q),
    .bus_din   (bus_din),
    .txq_data  (txq_data),
    .bus_dout  (bus_dout),
    .rd_en1    (rd_en1),
    .rd_en2    (rd_en2),
    .wr_en     (wr_en),
    .half_sel  (half_sel),
    .txq_pop   (txq_pop),
    .rx1q_push (rx1q_push),
    .rx2q_push (rx2q_push),
    .rxq_wdata (rxq_wdata)
  );

  // R3: nothing is granted to a channel that is not eligible
  a_r3_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !half_sel) |-> ($past(!txq_empty) && $past(!tx_hfull)));
  a_r3_rx1_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en1 && !half_sel) |-> ($past(!rx1_rdy_n) && $past(!rx1q_full)));
endmodule

// File: tb/shpath_arbiter_test.sv
module shpath_arbiter_test;
  localparam int CAP = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx1_rdy_n, rx2_rdy_n, tx_hfull;
  logic [15:0] bus_din, bus_dout;
  logic        rd_en1, rd_en2, wr_en, half_sel;
  logic        txq_empty;
  logic [31:0] txq_data;
  logic        txq_pop;
  logic        rx1q_full, rx2q_full, rx1q_push, rx2q_push;
  logic [31:0] rxq_wdata;
  logic [31:0] c1_head, c2_head;

  always #2 clk = ~clk;

  shpath_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rx1_rdy_n(rx1_rdy_n), .rx2_rdy_n(rx2_rdy_n),
    .tx_hfull(tx_hfull), .bus_din(bus_din), .bus_dout(bus_dout),
    .rd_en1(rd_en1), .rd_en2(rd_en2), .wr_en(wr_en), .half_sel(half_sel),
    .txq_empty(txq_empty), .txq_data(txq_data), .txq_pop(txq_pop),
    .rx1q_full(rx1q_full), .rx2q_full(rx2q_full), .rx1q_push(rx1q_push),
    .rx2q_push(rx2q_push), .rxq_wdata(rxq_wdata)
  );

  // Controller side: the selected receiver presents the requested half
  assign bus_din = rd_en1 ? (half_sel ? c1_head[31:16] : c1_head[15:0]) :
                   rd_en2 ? (half_sel ? c2_head[31:16] : c2_head[15:0]) : 16'h0;

  logic [31:0] c1q[$], c2q[$], tq[$], s1q[$], s2q[$], log1[$];
  int          grants[$];
  int          nchk = 0, nfail = 0;
  bit          done = 0;
  int          ms = 0;   // model: 0 wait, 1 tx, 2 rx1, 3 rx2, 4 clear
  bit          mh = 0;
  bit          f1_force = 0, f2_force = 0, hf = 0;
  int          drained1 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [6:0]  e, a;
    logic [15:0] ed;
    string       tag;
    e = {ms == 2, ms == 3, ms == 1, (ms >= 1 && ms <= 3) && mh,
         ms == 1 && mh, ms == 2 && mh, ms == 3 && mh};
    a = {rd_en1, rd_en2, wr_en, half_sel, txq_pop, rx1q_push, rx2q_push};
    if (!rst_n)       tag = "R1";
    else if (ms == 4) tag = "R7";
    else if (ms == 0) tag = "R2/R3";
    else              tag = "R4/R9";
    chk(a == e, {tag, " strobes"}, {25'h0, a}, {25'h0, e});
    ed = (ms == 1) ? (mh ? tq[0][31:16] : tq[0][15:0]) : 16'h0;
    chk(bus_dout == ed, (ms == 1) ? "R6 bus_dout" : {tag, " bus_dout"},
        {16'h0, bus_dout}, {16'h0, ed});
    if (ms == 2 && mh)      chk(rxq_wdata == c1q[0], "R5 rx1 word", rxq_wdata, c1q[0]);
    else if (ms == 3 && mh) chk(rxq_wdata == c2q[0], "R5 rx2 word", rxq_wdata, c2q[0]);
    else chk(rxq_wdata == 32'h0, {tag, " rxq_wdata idle"}, rxq_wdata, 32'h0);
    chk($onehot0({rd_en1, rd_en2, wr_en}), "R8 one strobe",
        {29'h0, rd_en1, rd_en2, wr_en}, 32'h0);
    if (rd_en1 && !half_sel) grants.push_back(1);
    if (rd_en2 && !half_sel) grants.push_back(2);
    if (wr_en  && !half_sel) grants.push_back(3);
  endtask

  task automatic drive();
    rx1_rdy_n = (c1q.size() == 0);
    rx2_rdy_n = (c2q.size() == 0);
    c1_head   = (c1q.size() != 0) ? c1q[0] : 32'h0;
    c2_head   = (c2q.size() != 0) ? c2q[0] : 32'h0;
    txq_empty = (tq.size() == 0);
    txq_data  = (tq.size() != 0) ? tq[0] : 32'h0;
    rx1q_full = f1_force || (s1q.size() >= CAP);
    rx2q_full = f2_force || (s2q.size() >= CAP);
    tx_hfull  = hf;
  endtask

  // One cycle: compare at the falling edge, apply queue effects, update drives
  task automatic step();
    @(negedge clk);
    compare();
    if (ms == 2 && mh) begin s1q.push_back(c1q[0]); void'(c1q.pop_front()); end
    if (ms == 3 && mh) begin s2q.push_back(c2q[0]); void'(c2q.pop_front()); end
    if (ms == 1 && mh) void'(tq.pop_front());
    drive();
    if (!rst_n) begin
      ms = 0; mh = 0;
    end else begin
      case (ms)
        0: begin
          mh = 0;
          if (!rx1_rdy_n && !rx1q_full)      ms = 2;
          else if (!rx2_rdy_n && !rx2q_full) ms = 3;
          else if (!txq_empty && !tx_hfull)  ms = 1;
        end
        1, 2, 3: if (!mh) mh = 1; else begin mh = 0; ms = 4; end
        default: ms = 0;
      endcase
    end
  endtask

  function automatic logic [31:0] rword();
    return $urandom;
  endfunction

  initial begin
    rst_n = 1'b0;
    drive();
    // R1: reset state
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    step();

    // Directed: all three eligible together (R2 priority)
    for (int i = 0; i < 2; i++) begin
      logic [31:0] w;
      w = rword(); c1q.push_back(w); log1.push_back(w);
      c2q.push_back(rword());
      tq.push_back(rword());
    end
    for (int i = 0; i < 30; i++) step();
    chk(grants.size() == 6, "R2 grant count", grants.size(), 6);
    if (grants.size() == 6) begin
      chk(grants[0] == 1 && grants[1] == 1, "R2 rx1 first", grants[0], 1);
      chk(grants[2] == 2 && grants[3] == 2, "R2 rx2 second", grants[2], 2);
      chk(grants[4] == 3 && grants[5] == 3, "R2 tx last", grants[4], 3);
    end
    chk(s1q.size() == 2 && s2q.size() == 2, "R5 words stored", s1q.size(), 2);

    // Blocked channels: R3 eligibility
    grants.delete();
    f1_force = 1; hf = 1;
    begin
      logic [31:0] w;
      w = rword(); c1q.push_back(w); log1.push_back(w);
    end
    tq.push_back(rword());
    for (int i = 0; i < 20; i++) step();
    chk(grants.size() == 0, "R3 blocked rx1 and tx", grants.size(), 0);
    f1_force = 0;
    for (int i = 0; i < 10; i++) step();
    chk(grants.size() == 1 && grants[0] == 1, "R3 rx1 after release", grants.size(), 1);
    for (int i = 0; i < 10; i++) step();
    chk(grants.size() == 1, "R3 tx held by half-full", grants.size(), 1);
    hf = 0;
    for (int i = 0; i < 10; i++) step();
    chk(tq.size() == 0, "R6 tx sent after release", tq.size(), 0);

    // Random: flags and queue status change on any cycle (R9)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0 && c1q.size() < 8) begin
        logic [31:0] w;
        w = rword(); c1q.push_back(w); log1.push_back(w);
      end
      if ($urandom % 6 == 0 && c2q.size() < 8) c2q.push_back(rword());
      if ($urandom % 5 == 0 && tq.size() < 8)  tq.push_back(rword());
      hf       = ($urandom % 4 == 0);
      f1_force = ($urandom % 8 == 0);
      f2_force = ($urandom % 8 == 0);
      if (s1q.size() != 0 && $urandom % 5 == 0) begin
        chk(s1q[0] == log1[drained1], "R5 rx1 order", s1q[0], log1[drained1]);
        void'(s1q.pop_front());
        drained1++;
      end
      if (s2q.size() != 0 && $urandom % 5 == 0) void'(s2q.pop_front());
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule